// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This block applies one single-bit operation to an operand: test, set, clear or invert a chosen bit. It also performs a byte test-and-set, which fills the negative and zero flags from the low byte and then forces that byte's top bit to one. Every operation returns the new operand and an updated flag set. Flags that an operation does not own pass through from the flag input unchanged.

The operand is either a full 32-bit register value or a byte fetched from memory. The byte sits in bits 7:0 of the operand input. The bit number comes from an immediate field or from the low bits of a register, and an input selects which. The wrap of the bit number depends on the operand kind. A one-cycle request pulse starts an operation. The result and a valid strobe appear in the next cycle, and the result is held until the next request. Address calculation, bus traffic and locking of read-modify-write cycles belong to the surrounding datapath.

Top module: `bitop_unit`

## Requirements
- R1: After reset `valid_o` is 0, and `result_o` and `flags_o` are all zero.
- R2: `valid_o` is 1 in exactly the cycle after a cycle with `req_i` high and 0 otherwise. `result_o` and `flags_o` do not change in a cycle that follows a cycle without a request.
- R3: For test, set, clear and invert (op codes 0, 1, 2, 3), the zero flag (`flags_o[2]`) equals the inverse of the selected bit as it was before the operation.
- R4: Test (op 0) returns the operand unchanged.
- R5: Set (op 1) forces the selected bit to 1, clear (op 2) forces it to 0, and invert (op 3) flips it. No other bit changes.
- R6: With `mem_i`=0 the bit number is taken modulo 32 over bits 31:0, where bit 0 is the LSB. With `mem_i`=1 it is taken modulo 8, and bits 31:8 of the result equal the operand.
- R7: With `use_reg_num_i`=1 the bit number is `reg_num_i`; otherwise it is `imm_num_i`.
- R8: Flag layout is X=[4], N=[3], Z=[2], V=[1], C=[0]. Ops 0 to 3 copy X, N, V and C from `flags_i`.
- R9: Test-and-set (op 4) always works on bits 7:0, whatever `mem_i` is. It sets N to the original bit 7, sets Z to 1 when the original byte is zero, clears V and C, and keeps X. The result equals the operand with bit 7 forced to 1.
- R10: Op codes 5 to 7 are reserved and behave exactly like test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an operation this cycle |
| op_i | input | 3 | 0 test, 1 set, 2 clear, 3 invert, 4 test-and-set, 5-7 reserved |
| mem_i | input | 1 | 1: byte memory operand, 0: 32-bit register operand |
| use_reg_num_i | input | 1 | Bit number source: 1 register, 0 immediate |
| imm_num_i | input | 8 | Immediate bit number |
| reg_num_i | input | 8 | Low bits of the register holding the bit number |
| operand_i | input | 32 | Operand (byte in bits 7:0 when `mem_i`=1) |
| flags_i | input | 5 | Incoming X,N,Z,V,C |
| valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 32 | Modified operand |
| flags_o | output | 5 | Updated X,N,Z,V,C |

## Verification
The checker watches several properties on every cycle. It checks the request-to-valid timing and that outputs hold in idle cycles. It also checks that test leaves the operand unchanged, that set, clear and invert differ from the operand in at most one bit, and that byte mode leaves bits 31:8 alone. Finally it checks that X is always kept and that test-and-set clears V and C. Other properties need the bench's chosen operands to show them. These are the exact wrap of the bit number in each mode, the choice between register and immediate bit numbers, the polarity of Z against the original bit, and test-and-set on a zero byte and on a negative byte.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [2:0] {
    OP_TEST = 3'd0,
    OP_SET  = 3'd1,
    OP_CLR  = 3'd2,
    OP_CHG  = 3'd3,
    OP_TAS  = 3'd4
  } bit_op_e;

  localparam int FLAG_W = 5;
  localparam int FL_X = 4;
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_V = 1;
  localparam int FL_C = 0;
endpackage

// File: rtl/bitop_num_sel.sv
module bitop_num_sel #(
  parameter int NUM_W  = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic             use_reg_i,
  input  logic             mem_i,
  input  logic [NUM_W-1:0] imm_num_i,
  input  logic [NUM_W-1:0] reg_num_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [NUM_W-1:0] num;
  logic [NUM_W-1:0] wrapped;

  always_comb begin
    num     = use_reg_i ? reg_num_i : imm_num_i;
    // byte operands wrap on the byte width, registers on the word width
    wrapped = mem_i ? (num % NUM_W'(BYTE_W)) : (num % NUM_W'(DATA_W));
    idx_o   = IDX_W'(wrapped);
  end
endmodule

// File: rtl/bitop_mask_gen.sv
module bitop_mask_gen #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask_o[i] = (idx_i == IDX_W'(i));
  end
endmodule

// File: rtl/bitop_core.sv
module bitop_core
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [DATA_W-1:0] TAS_MASK = DATA_W'(1) << (BYTE_W - 1);

  logic sel_bit;
  logic byte_zero;

  always_comb begin
    sel_bit   = |(operand_i & mask_i);
    byte_zero = ~|operand_i[BYTE_W-1:0];
    result_o  = operand_i;
    flags_o   = flags_i;
    flags_o[FL_Z] = ~sel_bit;
    unique case (op_i)
      OP_SET: result_o = operand_i | mask_i;
      OP_CLR: result_o = operand_i & ~mask_i;
      OP_CHG: result_o = operand_i ^ mask_i;
      OP_TAS: begin
        result_o      = operand_i | TAS_MASK;
        flags_o[FL_N] = operand_i[BYTE_W-1];
        flags_o[FL_Z] = byte_zero;
        flags_o[FL_V] = 1'b0;
        flags_o[FL_C] = 1'b0;
      end
      default: result_o = operand_i;  // test and reserved codes
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int NUM_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic              mem_i,
  input  logic              use_reg_num_i,
  input  logic [NUM_W-1:0]  imm_num_i,
  input  logic [NUM_W-1:0]  reg_num_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] res_d;
  logic [FLAG_W-1:0] flg_d;

  bitop_num_sel #(.NUM_W(NUM_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_num (
    .use_reg_i (use_reg_num_i),
    .mem_i     (mem_i),
    .imm_num_i (imm_num_i),
    .reg_num_i (reg_num_i),
    .idx_o     (idx)
  );

  bitop_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .idx_i  (idx),
    .mask_o (mask)
  );

  bitop_core #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_core (
    .op_i      (op_i),
    .operand_i (operand_i),
    .mask_i    (mask),
    .flags_i   (flags_i),
    .result_o  (res_d),
    .flags_o   (flg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        result_o <= res_d;
        flags_o  <= flg_d;
      end
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [2:0]        op_i,
  input logic              mem_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic [FLAG_W-1:0] flags_o
);
  logic bit_op;
  assign bit_op = (op_i == OP_SET) || (op_i == OP_CLR) || (op_i == OP_CHG);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);  // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(result_o) && $stable(flags_o)));  // R2
  AST_TEST_UNCHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == OP_TEST) |=> result_o == $past(operand_i));  // R4
  AST_SINGLE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && bit_op) |=> $countones(result_o ^ $past(operand_i)) <= 1);  // R5
  AST_BYTE_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mem_i) |=> result_o[DATA_W-1:BYTE_W] == $past(operand_i[DATA_W-1:BYTE_W]));  // R6
  AST_X_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> flags_o[FL_X] == $past(flags_i[FL_X]));  // R8
  AST_TAS_VC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == OP_TAS) |=> (flags_o[FL_V] == 1'b0 && flags_o[FL_C] == 1'b0));  // R9
  AST_TAS_TOP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == OP_TAS) |=> result_o[BYTE_W-1]);  // R9
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .op_i      (op_i),
  .mem_i     (mem_i),
  .operand_i (operand_i),
  .flags_i   (flags_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .flags_o   (flags_o)
);

// File: tb/bitop_unit_tb.sv
`timescale 1ns/1ps
module bitop_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  op = '0;
  logic        mem = 1'b0;
  logic        use_reg = 1'b0;
  logic [7:0]  imm_num = '0;
  logic [7:0]  reg_num = '0;
  logic [31:0] opd = '0;
  logic [4:0]  fl_in = '0;
  logic        valid;
  logic [31:0] result;
  logic [4:0]  fl_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bitop_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .mem_i(mem),
    .use_reg_num_i(use_reg), .imm_num_i(imm_num), .reg_num_i(reg_num),
    .operand_i(opd), .flags_i(fl_in), .valid_o(valid), .result_o(result),
    .flags_o(fl_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [36:0] model(input logic [2:0] o, input logic m, input logic ur,
                                        input logic [7:0] im, input logic [7:0] rn,
                                        input logic [31:0] d, input logic [4:0] f);
    logic [7:0]  num;
    int          idx;
    logic [31:0] r;
    logic [4:0]  nf;
    num = ur ? rn : im;
    idx = m ? int'(num) % 8 : int'(num) % 32;
    r   = d;
    nf  = f;
    if (o == 3'd4) begin
      nf = {f[4], d[7], (d[7:0] == 8'h00), 1'b0, 1'b0};
      r[7] = 1'b1;
    end else begin
      nf[2] = ~d[idx];
      case (o)
        3'd1: r[idx] = 1'b1;
        3'd2: r[idx] = 1'b0;
        3'd3: r[idx] = ~d[idx];
        default: ;
      endcase
    end
    return {nf, r};
  endfunction

  task automatic run_op(input logic [2:0] o, input logic m, input logic ur,
                        input logic [7:0] im, input logic [7:0] rn,
                        input logic [31:0] d, input logic [4:0] f,
                        input string rtag, input string ftag);
    logic [36:0] e;
    logic [31:0] held;
    e = model(o, m, ur, im, rn, d, f);
    @(negedge clk);
    req = 1'b1; op = o; mem = m; use_reg = ur; imm_num = im; reg_num = rn; opd = d; fl_in = f;
    @(negedge clk);
    req = 1'b0;
    chk("R2 valid", {31'd0, valid}, 32'd1);
    chk(rtag, result, e[31:0]);
    chk(ftag, {27'd0, fl_out}, {27'd0, e[36:32]});
    if (o != 3'd4)
      chk("R8 XNVC", {28'd0, fl_out[4], fl_out[3], fl_out[1], fl_out[0]},
          {28'd0, f[4], f[3], f[1], f[0]});
    held = result;
    opd = ~d; fl_in = ~f;
    @(negedge clk);
    chk("R2 idle valid", {31'd0, valid}, 32'd0);
    chk("R2 idle hold", result, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'd0, valid}, 32'd0);
    chk("R1 result", result, 32'd0);
    chk("R1 flags", {27'd0, fl_out}, 32'd0);
    rst_n = 1'b1;

    // directed corners
    run_op(3'd0, 1'b0, 1'b0, 8'd31, 8'd0, 32'h8000_0000, 5'b1_1011, "R4 msb test", "R3 msb set");
    run_op(3'd0, 1'b0, 1'b0, 8'd0,  8'd0, 32'hFFFF_FFFE, 5'b0_0100, "R4 lsb test", "R3 lsb clear");
    run_op(3'd1, 1'b0, 1'b0, 8'd33, 8'd0, 32'h0000_0000, 5'b1_0000, "R6 reg wrap 33", "R3");
    run_op(3'd2, 1'b1, 1'b0, 8'd15, 8'd0, 32'hA5A5_A5FF, 5'b0_1111, "R6 mem wrap 15", "R3");
    run_op(3'd3, 1'b1, 1'b0, 8'd12, 8'd0, 32'h1234_5600, 5'b0_0000, "R6 mem wrap 12", "R3");
    run_op(3'd1, 1'b0, 1'b1, 8'd3,  8'd200, 32'h0000_0000, 5'b0_0000, "R7 reg source", "R3");
    run_op(3'd3, 1'b0, 1'b0, 8'd9,  8'd2, 32'h0000_0200, 5'b1_0101, "R7 imm source", "R3");
    run_op(3'd4, 1'b0, 1'b0, 8'd0,  8'd0, 32'hDEAD_BE00, 5'b1_0011, "R9 zero byte", "R9 zero flags");
    run_op(3'd4, 1'b1, 1'b0, 8'd0,  8'd0, 32'h0000_0081, 5'b0_0111, "R9 neg byte", "R9 neg flags");
    run_op(3'd6, 1'b0, 1'b0, 8'd4,  8'd0, 32'h0000_0010, 5'b1_1111, "R10 reserved", "R10 flags");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      string rt;
      string ft;
      o = 3'($urandom % 8);
      rt = (o == 3'd0) ? "R4 rand" : (o == 3'd4) ? "R9 rand" : (o > 3'd4) ? "R10 rand" : "R5 rand";
      ft = (o == 3'd4) ? "R9 rand flags" : "R3 rand flags";
      run_op(o, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), $urandom, 5'($urandom), rt, ft);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule